// File: doc/BRIEF.md
# Control-Transfer Resolver

This block settles conditional branches and direct jumps for a 32-bit-instruction integer core. Each cycle in which `in_valid` is high it takes one instruction word, the address of that instruction, the two source operand values and three configuration bits that describe compressed-instruction support. It rebuilds the scattered immediate of the jump and branch formats, evaluates the branch condition and forms the target address. It then decides whether the control flow is redirected, whether a link register write is due, and whether an instruction-address-misaligned fault must be raised instead.

All results are registered. They appear one clock after the instruction is presented. The core supplies operands that are already resolved. Fetch, the register file and trap delivery sit outside this block. A parameter adds a register-indirect jump path that shares the alignment check.

Top module: `ctl_xfer_unit`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Results appear exactly one clock after a cycle with `in_valid` high, with `o_valid` set. One clock after a cycle with `in_valid` low, every output is 0.
- R3: Opcode 1101111 is a direct jump. Its offset is sign-extended and built as follows: word bit 31 gives offset[20], bits 19:12 give offset[19:12], bit 20 gives offset[11], bits 30:21 give offset[10:1], and offset[0] is 0. The target is the instruction address plus this offset, and `o_next_pc` carries it when no fault occurs.
- R4: Opcode 1100011 is a conditional branch. Its offset is sign-extended and built as follows: word bit 31 gives offset[12], bit 7 gives offset[11], bits 30:25 give offset[10:5], bits 11:8 give offset[4:1], and offset[0] is 0. A taken branch targets the instruction address plus this offset.
- R5: The branch condition is selected by word bits 14:12. Code 000 tests equal and 001 tests not equal. Code 100 tests signed less-than and 101 tests signed greater-or-equal. Code 110 tests unsigned less-than and 111 tests unsigned greater-or-equal.
- R6: An instruction that does not transfer control sets `o_next_pc` to its address plus 4, with `o_redirect`, `o_misalign` and `o_link_we` at 0. This covers a not-taken branch, whatever its target's alignment.
- R7: A transfer that is taken, whose target has bit 1 set while compressed support is off, raises `o_misalign` with `o_bad_addr` equal to the target. In that case `o_redirect` is 0 and `o_next_pc` holds the faulting instruction's own address. Without a fault, `o_bad_addr` is 0.
- R8: Compressed support counts as on when `c_impl` and `c_en` are both 1. It also counts as on when `subset_impl` is 1 and `c_impl` is 0. Otherwise it is off.
- R9: A jump that completes without a fault sets `o_link_we`, drives `o_link_rd` from word bits 11:7, and sets `o_link_val` to the instruction address plus 4. The write is suppressed on a fault or when the destination index is 0, and both link fields are then 0.
- R10: With `HAS_JALR` set, opcode 1100111 with bits 14:12 equal to 000 is a register-indirect jump. Its target is `src_a` plus the sign-extended word bits 31:20, with bit 0 forced to 0. It uses the alignment and link rules of R7 and R9.
- R11: Branch codes 010 and 011, and every other opcode, are treated as not transferring control (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| c_impl | input | 1 | Full compressed set is implemented |
| c_en | input | 1 | Enable bit of the full compressed set |
| subset_impl | input | 1 | Reduced compressed subset is implemented |
| o_valid | output | 1 | Results below belong to the instruction of the previous cycle |
| o_redirect | output | 1 | Control flow moves to `o_next_pc` |
| o_next_pc | output | XLEN | Next fetch address, or the faulting address on a fault |
| o_link_we | output | 1 | Link register write request |
| o_link_rd | output | 5 | Link destination index |
| o_link_val | output | XLEN | Link value (instruction address + 4) |
| o_misalign | output | 1 | Instruction-address-misaligned fault |
| o_bad_addr | output | XLEN | Target that caused the fault |

## Verification
Every result of this block sits in a single output register, so all outputs belonging to an instruction are due on the first rising edge after the cycle in which it is presented. The bench drives each instruction on a falling edge. It waits for the next rising edge and samples a short delay after it, so every comparison lands in the cycle the results are due and never at an edge. An idle cycle is checked the same way, with all outputs expected at 0 in the following cycle.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

    localparam logic [6:0] OPC_JUMP   = 7'b1101111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_INDJMP = 7'b1100111;

    typedef enum logic [2:0] {
        CND_EQ  = 3'b000,
        CND_NE  = 3'b001,
        CND_LT  = 3'b100,
        CND_GE  = 3'b101,
        CND_LTU = 3'b110,
        CND_GEU = 3'b111
    } cond_code_e;

    typedef enum logic [1:0] {
        XK_NONE   = 2'd0,
        XK_JUMP   = 2'd1,
        XK_BRANCH = 2'd2,
        XK_INDJMP = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/cx_decode.sv
module cx_decode
    import ctl_xfer_pkg::*;
#(
    parameter bit HAS_JALR = 1'b1
) (
    input  logic [31:0] instr,
    output xfer_kind_e  kind,
    output logic [4:0]  dest
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic       br_code_ok;
    logic       ind_ok;

    assign opc  = instr[6:0];
    assign f3   = instr[14:12];
    assign dest = instr[11:7];

    // funct3 010 and 011 name no branch condition
    assign br_code_ok = (f3 != 3'b010) && (f3 != 3'b011);

    generate
        if (HAS_JALR) begin : g_ind
            assign ind_ok = (opc == OPC_INDJMP) && (f3 == 3'b000);
        end else begin : g_no_ind
            assign ind_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        kind = XK_NONE;
        if (opc == OPC_JUMP) begin
            kind = XK_JUMP;
        end else if ((opc == OPC_BRANCH) && br_code_ok) begin
            kind = XK_BRANCH;
        end else if (ind_ok) begin
            kind = XK_INDJMP;
        end
    end
endmodule

// File: rtl/cx_imm_unpack.sv
module cx_imm_unpack #(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    output logic [XLEN-1:0] j_off,
    output logic [XLEN-1:0] b_off,
    output logic [XLEN-1:0] i_off
);
    localparam int J_W = 21;
    localparam int B_W = 13;
    localparam int I_W = 12;

    logic [J_W-1:0] j_raw;
    logic [B_W-1:0] b_raw;
    logic [I_W-1:0] i_raw;

    assign j_raw = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
    assign b_raw = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    assign i_raw = instr[31:20];

    assign j_off = {{(XLEN-J_W){j_raw[J_W-1]}}, j_raw};
    assign b_off = {{(XLEN-B_W){b_raw[B_W-1]}}, b_raw};
    assign i_off = {{(XLEN-I_W){i_raw[I_W-1]}}, i_raw};
endmodule

// File: rtl/cx_cond_eval.sv
module cx_cond_eval
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      code,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            hit
);
    logic eq;
    logic lt_s;
    logic lt_u;

    assign eq   = (lhs == rhs);
    assign lt_s = ($signed(lhs) < $signed(rhs));
    assign lt_u = (lhs < rhs);

    always_comb begin
        unique case (code)
            CND_EQ:  hit = eq;
            CND_NE:  hit = !eq;
            CND_LT:  hit = lt_s;
            CND_GE:  hit = !lt_s;
            CND_LTU: hit = lt_u;
            CND_GEU: hit = !lt_u;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_JALR  = 1'b1,
    parameter int STEP_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            c_impl,
    input  logic            c_en,
    input  logic            subset_impl,
    output logic            o_valid,
    output logic            o_redirect,
    output logic [XLEN-1:0] o_next_pc,
    output logic            o_link_we,
    output logic [4:0]      o_link_rd,
    output logic [XLEN-1:0] o_link_val,
    output logic            o_misalign,
    output logic [XLEN-1:0] o_bad_addr
);
    localparam logic [XLEN-1:0] STEP   = XLEN'(STEP_BYTES);
    localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

    typedef struct packed {
        logic            vld;
        logic            redir;
        logic [XLEN-1:0] npc;
        logic            lwe;
        logic [4:0]      lrd;
        logic [XLEN-1:0] lval;
        logic            mis;
        logic [XLEN-1:0] bad;
    } res_t;

    xfer_kind_e      kind;
    logic [4:0]      dest;
    logic [XLEN-1:0] j_off;
    logic [XLEN-1:0] b_off;
    logic [XLEN-1:0] i_off;
    logic            cond_hit;

    res_t            res_d;
    res_t            res_q;

    cx_decode #(.HAS_JALR(HAS_JALR)) u_dec (
        .instr (instr),
        .kind  (kind),
        .dest  (dest)
    );

    cx_imm_unpack #(.XLEN(XLEN)) u_imm (
        .instr (instr),
        .j_off (j_off),
        .b_off (b_off),
        .i_off (i_off)
    );

    cx_cond_eval #(.XLEN(XLEN)) u_cmp (
        .code (instr[14:12]),
        .lhs  (src_a),
        .rhs  (src_b),
        .hit  (cond_hit)
    );

    always_comb begin
        logic            rvc_on;
        logic            take;
        logic            fault;
        logic            is_jump;
        logic [XLEN-1:0] seq_pc;
        logic [XLEN-1:0] tgt;

        rvc_on  = (c_impl && c_en) || (subset_impl && !c_impl);
        seq_pc  = pc + STEP;
        is_jump = (kind == XK_JUMP) || (kind == XK_INDJMP);

        unique case (kind)
            XK_JUMP: begin
                take = 1'b1;
                tgt  = pc + j_off;
            end
            XK_BRANCH: begin
                take = cond_hit;
                tgt  = pc + b_off;
            end
            XK_INDJMP: begin
                take = 1'b1;
                tgt  = (src_a + i_off) & LSB_CLR;
            end
            default: begin
                take = 1'b0;
                tgt  = seq_pc;
            end
        endcase

        fault = take && tgt[1] && !rvc_on;

        res_d = '0;
        if (in_valid) begin
            res_d.vld   = 1'b1;
            res_d.redir = take && !fault;
            res_d.mis   = fault;
            res_d.bad   = fault ? tgt : '0;
            if (fault) begin
                res_d.npc = pc;
            end else if (take) begin
                res_d.npc = tgt;
            end else begin
                res_d.npc = seq_pc;
            end
            res_d.lwe  = is_jump && !fault && (dest != 5'd0);
            res_d.lrd  = res_d.lwe ? dest : 5'd0;
            res_d.lval = res_d.lwe ? seq_pc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign o_valid    = res_q.vld;
    assign o_redirect = res_q.redir;
    assign o_next_pc  = res_q.npc;
    assign o_link_we  = res_q.lwe;
    assign o_link_rd  = res_q.lrd;
    assign o_link_val = res_q.lval;
    assign o_misalign = res_q.mis;
    assign o_bad_addr = res_q.bad;
endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] pc,
    input logic            o_valid,
    input logic            o_redirect,
    input logic [XLEN-1:0] o_next_pc,
    input logic            o_link_we,
    input logic [4:0]      o_link_rd,
    input logic            o_misalign,
    input logic [XLEN-1:0] o_bad_addr
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> o_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!o_valid && !o_redirect && !o_link_we && !o_misalign));

    p_sequential_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid ##1 (!o_redirect && !o_misalign)) |-> (o_next_pc == $past(pc) + XLEN'(4)));

    p_fault_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        o_misalign |-> (!o_redirect && !o_link_we && o_bad_addr[1]));

    p_fault_holds_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid ##1 o_misalign) |-> (o_next_pc == $past(pc)));

    p_link_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_link_we |-> (o_link_rd != 5'd0 && o_valid));

    p_redirect_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid ##1 o_redirect) |-> (o_next_pc[0] == 1'b0 || $past(pc[0])));
endmodule

bind ctl_xfer_unit cx_checker #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pc         (pc),
    .o_valid    (o_valid),
    .o_redirect (o_redirect),
    .o_next_pc  (o_next_pc),
    .o_link_we  (o_link_we),
    .o_link_rd  (o_link_rd),
    .o_misalign (o_misalign),
    .o_bad_addr (o_bad_addr)
);

// File: tb/sim_ctl_xfer_unit.sv
module sim_ctl_xfer_unit;
    localparam int XLEN = 32;

    typedef struct packed {
        logic            vld;
        logic            redir;
        logic [XLEN-1:0] npc;
        logic            lwe;
        logic [4:0]      lrd;
        logic [XLEN-1:0] lval;
        logic            mis;
        logic [XLEN-1:0] bad;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] pc = '0;
    logic [XLEN-1:0] src_a = '0;
    logic [XLEN-1:0] src_b = '0;
    logic            c_impl = 1'b0;
    logic            c_en = 1'b0;
    logic            subset_impl = 1'b0;
    logic            o_valid;
    logic            o_redirect;
    logic [XLEN-1:0] o_next_pc;
    logic            o_link_we;
    logic [4:0]      o_link_rd;
    logic [XLEN-1:0] o_link_val;
    logic            o_misalign;
    logic [XLEN-1:0] o_bad_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ctl_xfer_unit #(.XLEN(XLEN), .HAS_JALR(1'b1)) u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr),
        .pc (pc), .src_a (src_a), .src_b (src_b), .c_impl (c_impl),
        .c_en (c_en), .subset_impl (subset_impl), .o_valid (o_valid),
        .o_redirect (o_redirect), .o_next_pc (o_next_pc), .o_link_we (o_link_we),
        .o_link_rd (o_link_rd), .o_link_val (o_link_val), .o_misalign (o_misalign),
        .o_bad_addr (o_bad_addr)
    );

    // ---------------- encoders and reference model ----------------
    function automatic logic [31:0] enc_jump(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_branch(input logic [12:0] off, input logic [2:0] f3);
        return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_ind(input logic [11:0] imm, input logic [4:0] rd,
                                            input logic [2:0] f3);
        return {imm, 5'd1, f3, rd, 7'b1100111};
    endfunction

    function automatic logic rvc_of(input logic ci, input logic ce, input logic si);
        return (ci & ce) | (si & ~ci);
    endfunction

    function automatic exp_t finish_exp(input logic [XLEN-1:0] p, input logic take,
                                        input logic [XLEN-1:0] tgt, input logic jump,
                                        input logic [4:0] rd, input logic rvc);
        exp_t e;
        logic f;
        e = '0;
        e.vld = 1'b1;
        f = take && tgt[1] && !rvc;
        e.mis = f;
        e.bad = f ? tgt : '0;
        e.redir = take && !f;
        e.npc = f ? p : (take ? tgt : p + 32'd4);
        e.lwe = jump && !f && (rd != 0);
        e.lrd = e.lwe ? rd : 5'd0;
        e.lval = e.lwe ? p + 32'd4 : '0;
        return e;
    endfunction

    function automatic exp_t exp_jump(input logic [XLEN-1:0] p, input logic [20:0] off,
                                      input logic [4:0] rd, input logic rvc);
        return finish_exp(p, 1'b1, p + {{11{off[20]}}, off}, 1'b1, rd, rvc);
    endfunction

    function automatic exp_t exp_branch(input logic [XLEN-1:0] p, input logic [12:0] off,
                                        input logic [2:0] f3, input logic [XLEN-1:0] a,
                                        input logic [XLEN-1:0] b, input logic rvc);
        logic t;
        case (f3)
            3'b000:  t = (a == b);
            3'b001:  t = (a != b);
            3'b100:  t = ($signed(a) < $signed(b));
            3'b101:  t = ($signed(a) >= $signed(b));
            3'b110:  t = (a < b);
            3'b111:  t = (a >= b);
            default: return finish_exp(p, 1'b0, '0, 1'b0, 5'd0, rvc);
        endcase
        return finish_exp(p, t, p + {{19{off[12]}}, off}, 1'b0, 5'd0, rvc);
    endfunction

    function automatic exp_t exp_ind(input logic [XLEN-1:0] p, input logic [XLEN-1:0] a,
                                     input logic [11:0] imm, input logic [4:0] rd,
                                     input logic rvc);
        logic [XLEN-1:0] t;
        t = a + {{20{imm[11]}}, imm};
        t[0] = 1'b0;
        return finish_exp(p, 1'b1, t, 1'b1, rd, rvc);
    endfunction

    // ---------------- drive and compare ----------------
    task automatic compare(input exp_t e, input string tag);
        exp_t got;
        got = '{o_valid, o_redirect, o_next_pc, o_link_we, o_link_rd, o_link_val,
                o_misalign, o_bad_addr};
        n_checks++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b redir=%0b npc=%h lwe=%0b lrd=%0d lval=%h mis=%0b bad=%h | exp vld=%0b redir=%0b npc=%h lwe=%0b lrd=%0d lval=%h mis=%0b bad=%h",
                     tag, got.vld, got.redir, got.npc, got.lwe, got.lrd, got.lval, got.mis, got.bad,
                     e.vld, e.redir, e.npc, e.lwe, e.lrd, e.lval, e.mis, e.bad);
        end
    endtask

    task automatic apply(input logic v, input logic [31:0] w, input logic [XLEN-1:0] p,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic ci, input logic ce, input logic si,
                         input exp_t e, input string tag);
        @(negedge clk);
        in_valid = v; instr = w; pc = p; src_a = a; src_b = b;
        c_impl = ci; c_en = ce; subset_impl = si;
        @(posedge clk);
        #2;
        compare(e, tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        #2;
        compare('0, "R1 reset");

        @(negedge clk);
        rst_n = 1'b1;

        // R3: most negative jump offset, aligned, compressed off
        apply(1, enc_jump(21'h100000, 5'd1), 32'h0040_0000, 0, 0, 0, 0, 0,
              exp_jump(32'h0040_0000, 21'h100000, 5'd1, 1'b0), "R3 jump max negative");
        // R3: positive offset touching every field
        apply(1, enc_jump(21'h0ABCD4, 5'd5), 32'h0000_1000, 0, 0, 0, 0, 0,
              exp_jump(32'h0000_1000, 21'h0ABCD4, 5'd5, 1'b0), "R3 jump field mix");
        // R7 R9: target bit 1 set, compressed off -> fault, no link
        apply(1, enc_jump(21'h000006, 5'd1), 32'h0000_2000, 0, 0, 0, 0, 0,
              exp_jump(32'h0000_2000, 21'h000006, 5'd1, 1'b0), "R7 jump misaligned fault");
        // R8: subset only -> compressed on, same jump redirects
        apply(1, enc_jump(21'h000006, 5'd1), 32'h0000_2000, 0, 0, 0, 0, 1,
              exp_jump(32'h0000_2000, 21'h000006, 5'd1, 1'b1), "R8 subset only enables");
        // R8: full set present but disabled, subset present -> still off
        apply(1, enc_jump(21'h000006, 5'd1), 32'h0000_2000, 0, 0, 1, 0, 1,
              exp_jump(32'h0000_2000, 21'h000006, 5'd1, 1'b0), "R8 full set disabled");
        // R8: full set enabled
        apply(1, enc_jump(21'h000006, 5'd3), 32'h0000_2000, 0, 0, 1, 1, 0,
              exp_jump(32'h0000_2000, 21'h000006, 5'd3, 1'b1), "R8 full set enabled");
        // R9: destination 0 suppresses link
        apply(1, enc_jump(21'h000010, 5'd0), 32'h0000_3000, 0, 0, 0, 0, 0,
              exp_jump(32'h0000_3000, 21'h000010, 5'd0, 1'b0), "R9 rd zero no link");
        // R4 R5: equal taken, field mix offset
        apply(1, enc_branch(13'h1A5C, 3'b000), 32'h0001_0000, 32'h77, 32'h77, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h1A5C, 3'b000, 32'h77, 32'h77, 1'b0), "R4 beq taken");
        apply(1, enc_branch(13'h0824, 3'b001), 32'h0001_0000, 32'h77, 32'h77, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h0824, 3'b001, 32'h77, 32'h77, 1'b0), "R5 bne not taken");
        // R5: signed vs unsigned on -1 vs 1
        apply(1, enc_branch(13'h0040, 3'b100), 32'h0001_0000, 32'hFFFF_FFFF, 32'h1, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h0040, 3'b100, 32'hFFFF_FFFF, 32'h1, 1'b0), "R5 signed lt");
        apply(1, enc_branch(13'h0040, 3'b110), 32'h0001_0000, 32'hFFFF_FFFF, 32'h1, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h0040, 3'b110, 32'hFFFF_FFFF, 32'h1, 1'b0), "R5 unsigned lt");
        apply(1, enc_branch(13'h0040, 3'b111), 32'h0001_0000, 32'hFFFF_FFFF, 32'h1, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h0040, 3'b111, 32'hFFFF_FFFF, 32'h1, 1'b0), "R5 unsigned ge");
        // R6: not-taken branch to misaligned target -> no fault
        apply(1, enc_branch(13'h0006, 3'b000), 32'h0001_0000, 32'h1, 32'h2, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h0006, 3'b000, 32'h1, 32'h2, 1'b0), "R6 not taken no fault");
        // R7: taken branch to misaligned target
        apply(1, enc_branch(13'h1FFA, 3'b101), 32'h0001_0000, 32'h5, 32'h5, 0, 0, 0,
              exp_branch(32'h0001_0000, 13'h1FFA, 3'b101, 32'h5, 32'h5, 1'b0), "R7 branch fault");
        // R11: reserved branch codes
        apply(1, enc_branch(13'h0040, 3'b010), 32'h0001_0000, 32'h5, 32'h5, 0, 0, 0,
              finish_exp(32'h0001_0000, 1'b0, '0, 1'b0, 5'd0, 1'b0), "R11 reserved code 010");
        apply(1, enc_branch(13'h0046, 3'b011), 32'h0001_0000, 32'h5, 32'h9, 0, 0, 0,
              finish_exp(32'h0001_0000, 1'b0, '0, 1'b0, 5'd0, 1'b0), "R11 reserved code 011");
        // R11: other opcode with jump-like fields
        apply(1, 32'h0000_0093, 32'h0001_0000, 0, 0, 0, 0, 0,
              finish_exp(32'h0001_0000, 1'b0, '0, 1'b0, 5'd0, 1'b0), "R11 other opcode");
        // R10: odd sum, bit 0 cleared
        apply(1, enc_ind(12'h005, 5'd1, 3'b000), 32'h0002_0000, 32'h0000_8000, 0, 0, 0, 0,
              exp_ind(32'h0002_0000, 32'h0000_8000, 12'h005, 5'd1, 1'b0), "R10 indirect lsb clear");
        // R10 R7: indirect jump misaligned
        apply(1, enc_ind(12'hFFE, 5'd1, 3'b000), 32'h0002_0000, 32'h0000_8000, 0, 0, 0, 0,
              exp_ind(32'h0002_0000, 32'h0000_8000, 12'hFFE, 5'd1, 1'b0), "R10 indirect fault");
        // R10 R11: indirect opcode with nonzero funct3
        apply(1, enc_ind(12'h010, 5'd1, 3'b001), 32'h0002_0000, 32'h0000_8000, 0, 0, 0, 0,
              finish_exp(32'h0002_0000, 1'b0, '0, 1'b0, 5'd0, 1'b0), "R10 indirect bad funct3");
        // R2: idle cycle gives zeros
        apply(0, enc_jump(21'h000010, 5'd1), 32'h0000_3000, 0, 0, 0, 0, 0,
              '0, "R2 idle");

        // Random mix: R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 400; i++) begin
            logic [XLEN-1:0] rp;
            logic [XLEN-1:0] ra;
            logic [XLEN-1:0] rb;
            logic            ci;
            logic            ce;
            logic            si;
            logic            rvc;
            logic [4:0]      rd;
            logic [2:0]      f3;
            int unsigned     sel;
            rp = $urandom() & 32'hFFFF_FFFE;
            ra = $urandom();
            rb = ($urandom_range(0, 3) == 0) ? ra : $urandom();
            ci = $urandom_range(0, 1);
            ce = $urandom_range(0, 1);
            si = $urandom_range(0, 1);
            rvc = rvc_of(ci, ce, si);
            rd = $urandom_range(0, 31);
            sel = $urandom_range(0, 2);
            if (sel == 0) begin
                logic [20:0] jo;
                jo = $urandom() & 21'h1FFFFE;
                apply(1, enc_jump(jo, rd), rp, ra, rb, ci, ce, si,
                      exp_jump(rp, jo, rd, rvc), "R3/R7/R9 random jump");
            end else if (sel == 1) begin
                logic [12:0] bo;
                bo = $urandom() & 13'h1FFE;
                f3 = $urandom_range(0, 7);
                apply(1, enc_branch(bo, f3), rp, ra, rb, ci, ce, si,
                      exp_branch(rp, bo, f3, ra, rb, rvc), "R4/R5/R6 random branch");
            end else begin
                logic [11:0] im;
                im = $urandom();
                apply(1, enc_ind(im, rd, 3'b000), rp, ra, rb, ci, ce, si,
                      exp_ind(rp, ra, im, rd, rvc), "R10/R8 random indirect");
            end
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule